// File: doc/BRIEF.md
# Inclusive Snoop Filter Directory

This block is a tag-only directory that sits beside a shared outer cache level whose tags are kept inclusive of every private inner cache. For each tracked line it records whether the line is absent, clean and shared by a set of cores, held by exactly one core with the outer data stale, or dirty in the outer level with no inner holder. Cores send reads, ownership requests (issued on an inner write miss) and writebacks. The directory answers with hit or miss, echoes the requesting core, and tells that core which state it may take. When another core must act first, the directory issues a snoop to exactly the cores that matter and waits for their acknowledgements before it answers.

The directory is 4-way set associative with a tree pseudo-LRU per set. A miss into a full set evicts a victim, and any inner copies of the victim are recalled first. The line address is split so that the low bits pick the set and the remaining bits form the tag. One request is handled at a time: `req_ready` is low from acceptance until the response has been issued. Data arrays, memory and the inner caches live outside the block.

Top module: `sf_dir`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1 and `rsp_valid` and `snp_valid` are 0; every entry starts absent, so the first request to any line misses.
- R2: A read (op 0) that misses allocates the line clean-shared with the requester as sole holder and grants shared (grant 1, hit 0). A read that hits a clean-shared or outer-dirty line adds the requester, grants shared, snoops nobody, and the response appears exactly two cycles after the accepting edge.
- R3: An ownership request (op 1) hitting a clean-shared line sends one snoop of kind 1 (invalidate) whose mask holds every other sharer and never the requester. The response comes two cycles after the cycle in which the last of those cores asserts its `snp_ack` bit, and grants exclusive (grant 2).
- R4: A read from a core other than the recorded owner of a held line snoops the owner alone with kind 3 (write back and keep a shared copy); afterwards the line is clean-shared by the old owner and the requester, and the grant is shared.
- R5: An ownership request from a non-owner on a held line snoops the owner alone with kind 2 (write back and invalidate); the requester becomes the owner and is granted exclusive.
- R6: A writeback (op 2) from the recorded owner answers hit with grant 0 and leaves the line dirty in the outer level with no holder, so the next read or ownership request of that line snoops nobody.
- R7: A writeback from a core that is not the owner, or to an absent line, answers grant 0 (hit 1 or 0 as the lookup found) and changes no entry and no victim order.
- R8: A miss into a set that still has an absent way takes the lowest such way and sends no snoop of any kind.
- R9: A miss into a full set recalls the victim before reuse: a clean-shared victim gets a kind 1 snoop to all its sharers, a held victim gets a kind 2 snoop to its owner, an outer-dirty victim gets none; the snoop address is the victim's line address.
- R10: The victim in a full set follows a 3-bit tree pseudo-LRU updated on every allocation and on every hit except an ignored writeback: after filling ways 0..3 in order the next miss evicts way 0, and after a further hit on way 0 it evicts way 2.
- R11: `req_ready` drops on the cycle after an accepted request and stays low until the response cycle; each snoop and each response is a single-cycle pulse.
- R12: A read or ownership request from the core already recorded as owner answers hit, grants exclusive and snoops nobody.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_core | input | CW | Requesting core index |
| req_op | input | 2 | 0 read, 1 ownership request, 2 writeback |
| req_addr | input | AW | Line address; low bits select the set |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | CW | Core the response belongs to |
| rsp_hit | output | 1 | Line was tracked at lookup |
| rsp_grant | output | 2 | 0 none, 1 shared, 2 exclusive |
| snp_valid | output | 1 | Snoop pulse |
| snp_mask | output | NC | Cores that must act on the snoop |
| snp_kind | output | 2 | 1 invalidate, 2 write back and invalidate, 3 write back and keep shared |
| snp_addr | output | AW | Line address the snoop refers to |
| snp_ack | input | NC | Per-core acknowledgement pulses |

## Verification
The hardest situations to reach are victim recalls, since they need a set filled with lines in particular states and a pseudo-LRU order that points at a chosen way. The stimulus fills separate sets with lines left clean-shared, owned, or written back to the outer level, replays a hit to bend the replacement tree, and then forces a fifth miss, so every recall kind appears once and the tree result differs from true LRU. Acknowledgements arrive staggered per core so that a response issued before the last acknowledgement would show up as a wrong latency.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int WAYS = 4;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_RFO = 2'd1, OP_WB = 2'd2, OP_NOP = 2'd3} sf_op_e;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_OWN = 2'd2, LS_MOD = 2'd3} sf_lstate_e;
  typedef enum logic [1:0] {GR_NONE = 2'd0, GR_SHR = 2'd1, GR_EXC = 2'd2} sf_grant_e;
  typedef enum logic [1:0] {SK_NONE = 2'd0, SK_INV = 2'd1, SK_FINV = 2'd2, SK_FSHR = 2'd3} sf_snp_e;

  // b[0]: 0 -> victim in ways 0/1, 1 -> ways 2/3; b[1], b[2] pick within each half
  function automatic logic [1:0] plru_pick(input logic [2:0] b);
    if (!b[0]) return b[1] ? 2'd1 : 2'd0;
    return b[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] r;
    r = b;
    if (!w[1]) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/sf_tag_store.sv
module sf_tag_store
  import sf_pkg::*;
#(
  parameter int SETS = 16,
  parameter int PW   = 18
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic [$clog2(SETS)-1:0]        rd_set,
  output logic [WAYS-1:0][1:0]           rd_st,
  output logic [WAYS-1:0][PW-1:0]        rd_pl,
  input  logic                           wr_en,
  input  logic [$clog2(SETS)-1:0]        wr_set,
  input  logic [1:0]                     wr_way,
  input  logic [1:0]                     wr_st,
  input  logic [PW-1:0]                  wr_pl
);
  // Line state lives in resettable flops; tag/owner/presence in RAM-style arrays.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [PW-1:0] pl_mem [SETS];
    logic [1:0]    st_mem [SETS];
    logic [PW-1:0] pl_q;
    logic [1:0]    st_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == 2'(w)) pl_mem[wr_set] <= wr_pl;
      if (rd_en) pl_q <= pl_mem[rd_set];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SETS; s++) st_mem[s] <= LS_INV;
        st_q <= LS_INV;
      end else begin
        if (wr_en && wr_way == 2'(w)) st_mem[wr_set] <= wr_st;
        if (rd_en) st_q <= st_mem[rd_set];
      end
    end

    assign rd_pl[w] = pl_q;
    assign rd_st[w] = st_q;
  end
endmodule

// File: rtl/sf_plru.sv
module sf_plru
  import sf_pkg::*;
#(
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic [1:0]              victim,
  input  logic                    upd_en,
  input  logic [$clog2(SETS)-1:0] upd_set,
  input  logic [1:0]              upd_way
);
  logic [2:0] tree_q [SETS];
  logic [1:0] vic_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      vic_q <= '0;
    end else begin
      if (upd_en) tree_q[upd_set] <= plru_touch(tree_q[upd_set], upd_way);
      if (rd_en) vic_q <= plru_pick(tree_q[rd_set]);
    end
  end

  assign victim = vic_q;
endmodule

// File: rtl/sf_dir.sv
module sf_dir
  import sf_pkg::*;
#(
  parameter int NC   = 4,
  parameter int SETS = 16,
  parameter int AW   = 16,
  localparam int CW  = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_core,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_core,
  output logic          rsp_hit,
  output logic [1:0]    rsp_grant,
  output logic          snp_valid,
  output logic [NC-1:0] snp_mask,
  output logic [1:0]    snp_kind,
  output logic [AW-1:0] snp_addr,
  input  logic [NC-1:0] snp_ack
);
  localparam int SW = $clog2(SETS);
  localparam int TW = AW - SW;
  localparam int PW = TW + CW + NC;   // payload: {tag, owner, presence}

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT, S_FIN} fsm_e;
  fsm_e fsm_q;

  logic [CW-1:0] core_q;
  sf_op_e        op_q;
  logic [AW-1:0] addr_q;

  logic [WAYS-1:0][1:0]    way_st;
  logic [WAYS-1:0][PW-1:0] way_pl;
  logic [1:0]              plru_vic;

  // lookup outputs held until the finish cycle
  logic [1:0]    way_q;
  logic          wr_q, hit_q;
  logic [1:0]    gnt_q;
  logic [1:0]    nst_q;
  logic [PW-1:0] npl_q;
  logic [NC-1:0] mask_q, ack_q;

  logic rd_en;
  assign req_ready = (fsm_q == S_IDLE);
  assign rd_en     = req_valid && req_ready;

  sf_tag_store #(.SETS(SETS), .PW(PW)) u_tags (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_set(req_addr[SW-1:0]), .rd_st(way_st), .rd_pl(way_pl),
    .wr_en(fsm_q == S_FIN && wr_q), .wr_set(addr_q[SW-1:0]), .wr_way(way_q),
    .wr_st(nst_q), .wr_pl(npl_q)
  );

  sf_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_set(req_addr[SW-1:0]), .victim(plru_vic),
    .upd_en(fsm_q == S_FIN && wr_q), .upd_set(addr_q[SW-1:0]), .upd_way(way_q)
  );

  // ---------------- lookup decision ----------------
  logic [SW-1:0] set_l;
  logic [TW-1:0] tag_l;
  logic          hit, free_any;
  logic [1:0]    hway, fway, sel;
  sf_lstate_e    c_st;
  logic [TW-1:0] c_tag;
  logic [CW-1:0] c_own;
  logic [NC-1:0] c_pres, cbit, obit;

  always_comb begin
    set_l    = addr_q[SW-1:0];
    tag_l    = addr_q[AW-1:SW];
    hit      = 1'b0;
    hway     = '0;
    free_any = 1'b0;
    fway     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_st[w] == LS_INV) begin
        free_any = 1'b1;
        fway     = 2'(w);
      end else if (way_pl[w][PW-1 -: TW] == tag_l) begin
        hit  = 1'b1;
        hway = 2'(w);
      end
    end
    sel    = hit ? hway : (free_any ? fway : plru_vic);
    c_st   = sf_lstate_e'(way_st[sel]);
    c_tag  = way_pl[sel][PW-1 -: TW];
    c_own  = way_pl[sel][NC +: CW];
    c_pres = way_pl[sel][NC-1:0];
    cbit   = NC'(1) << core_q;
    obit   = NC'(1) << c_own;
  end

  sf_lstate_e    n_st;
  logic [CW-1:0] n_own;
  logic [NC-1:0] n_pres, n_mask;
  sf_snp_e       n_kind;
  logic [AW-1:0] n_saddr;
  sf_grant_e     n_gnt;
  logic          n_wr;

  always_comb begin
    n_st    = c_st;
    n_own   = c_own;
    n_pres  = c_pres;
    n_mask  = '0;
    n_kind  = SK_NONE;
    n_saddr = addr_q;
    n_gnt   = GR_NONE;
    n_wr    = 1'b1;
    // victim recall ahead of reuse
    if (!hit && !free_any && (op_q == OP_READ || op_q == OP_RFO)) begin
      n_saddr = {c_tag, set_l};
      if (c_st == LS_SHR) begin
        n_mask = c_pres;
        n_kind = SK_INV;
      end else if (c_st == LS_OWN) begin
        n_mask = obit;
        n_kind = SK_FINV;
      end
    end
    case (op_q)
      OP_READ: begin
        n_gnt = GR_SHR;
        if (!hit) begin
          n_st   = LS_SHR;
          n_own  = core_q;
          n_pres = cbit;
        end else begin
          case (c_st)
            LS_SHR: n_pres = c_pres | cbit;
            LS_MOD: begin
              n_st   = LS_SHR;
              n_pres = cbit;
            end
            LS_OWN: begin
              if (c_own == core_q) n_gnt = GR_EXC;
              else begin
                n_mask = obit;
                n_kind = SK_FSHR;
                n_st   = LS_SHR;
                n_pres = obit | cbit;
              end
            end
            default: ;
          endcase
        end
      end
      OP_RFO: begin
        if (hit && c_st == LS_OWN && c_own != core_q) begin
          n_mask = obit;
          n_kind = SK_FINV;
        end else if (hit && c_st == LS_SHR) begin
          n_mask = c_pres & ~cbit;
          n_kind = (n_mask != '0) ? SK_INV : SK_NONE;
        end
        n_st   = LS_OWN;
        n_own  = core_q;
        n_pres = cbit;
        n_gnt  = GR_EXC;
      end
      OP_WB: begin
        if (hit && c_st == LS_OWN && c_own == core_q) begin
          n_st   = LS_MOD;
          n_pres = '0;
        end else n_wr = 1'b0;
      end
      default: n_wr = 1'b0;
    endcase
  end

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= S_IDLE;
      core_q    <= '0;
      op_q      <= OP_READ;
      addr_q    <= '0;
      way_q     <= '0;
      wr_q      <= 1'b0;
      hit_q     <= 1'b0;
      gnt_q     <= '0;
      nst_q     <= '0;
      npl_q     <= '0;
      mask_q    <= '0;
      ack_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_hit   <= 1'b0;
      rsp_grant <= '0;
      snp_valid <= 1'b0;
      snp_mask  <= '0;
      snp_kind  <= '0;
      snp_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      snp_valid <= 1'b0;
      case (fsm_q)
        S_IDLE: if (rd_en) begin
          core_q <= req_core;
          op_q   <= sf_op_e'(req_op);
          addr_q <= req_addr;
          fsm_q  <= S_LOOK;
        end
        S_LOOK: begin
          way_q  <= sel;
          wr_q   <= n_wr;
          hit_q  <= hit;
          gnt_q  <= n_gnt;
          nst_q  <= n_st;
          npl_q  <= {tag_l, n_own, n_pres};
          mask_q <= n_mask;
          ack_q  <= '0;
          if (n_mask != '0) begin
            snp_valid <= 1'b1;
            snp_mask  <= n_mask;
            snp_kind  <= n_kind;
            snp_addr  <= n_saddr;
            fsm_q     <= S_WAIT;
          end else fsm_q <= S_FIN;
        end
        S_WAIT: begin
          ack_q <= ack_q | snp_ack;
          if (((ack_q | snp_ack) & mask_q) == mask_q) fsm_q <= S_FIN;
        end
        S_FIN: begin
          rsp_valid <= 1'b1;
          rsp_core  <= core_q;
          rsp_hit   <= hit_q;
          rsp_grant <= gnt_q;
          fsm_q     <= S_IDLE;
        end
        default: fsm_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sf_dir_chk.sv
module sf_dir_chk #(
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          snp_valid,
  input logic [NC-1:0] snp_mask,
  input logic [1:0]    snp_kind
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !snp_valid && req_ready));

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_snoop_pulse: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> !snp_valid);

  a_r11_no_accept_while_snooping: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !req_ready);

  a_r8_snoop_nonempty: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> (snp_mask != '0 && snp_kind != 2'd0));

  a_r5_owner_only: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_kind != 2'd1) |-> ($countones(snp_mask) == 1));

  a_r3_rsp_after_acks: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> !rsp_valid);
endmodule

bind sf_dir sf_dir_chk #(.NC(NC)) u_chk (.*);

// File: tb/tb_sf_dir.sv
module tb_sf_dir;
  localparam int NC = 4, SETS = 16, AW = 16, CW = 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [CW-1:0] req_core = '0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_hit;
  logic [CW-1:0] rsp_core;
  logic [1:0] rsp_grant, snp_kind;
  logic snp_valid;
  logic [NC-1:0] snp_mask, snp_ack = '0;
  logic [AW-1:0] snp_addr;

  always #2 clk = ~clk;   // 250 MHz

  sf_dir #(.NC(NC), .SETS(SETS), .AW(AW)) dut (.*);

  int checks = 0, fails = 0;
  bit busy = 0, done = 0;
  // reference directory: 0 absent, 1 shared, 2 held by owner, 3 dirty in outer
  int m_st[int], m_own[int], m_pres[int];

  function automatic int mk(int tag, int set);
    return tag * SETS + set;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // nothing may come out while no request is in flight (R11)
  always @(negedge clk) if (!rst && !busy && (rsp_valid || snp_valid)) begin
    checks++; fails++;
    $display("FAIL R11 idle output actual=%0d expected=0", {rsp_valid, snp_valid});
  end

  task automatic req(int c, int op, int a, int vic, string rq);
    int hit, st, own, pres, em, ek, esa, eg, nst, nown, npres, upd, snp_seen, last_ack, got;
    int ack_at[NC];
    hit = m_st.exists(a); st = hit ? m_st[a] : 0;
    own = hit ? m_own[a] : 0; pres = hit ? m_pres[a] : 0;
    em = 0; ek = 0; esa = a; eg = 0; nst = st; nown = own; npres = pres; upd = 1;
    if (!hit && op != 2 && vic >= 0) begin
      esa = vic;
      if (m_st[vic] == 1) begin em = m_pres[vic]; ek = 1; end
      else if (m_st[vic] == 2) begin em = 1 << m_own[vic]; ek = 2; end
    end
    case (op)
      0: begin
        eg = 1;
        if (!hit) begin nst = 1; npres = 1 << c; nown = c; end
        else if (st == 1) npres = pres | (1 << c);
        else if (st == 3) begin nst = 1; npres = 1 << c; end
        else if (own == c) eg = 2;
        else begin em = 1 << own; ek = 3; nst = 1; npres = (1 << own) | (1 << c); end
      end
      1: begin
        if (hit && st == 2 && own != c) begin em = 1 << own; ek = 2; end
        else if (hit && st == 1) begin em = pres & ~(1 << c); ek = (em != 0) ? 1 : 0; end
        nst = 2; nown = c; npres = 1 << c; eg = 2;
      end
      default: begin
        if (hit && st == 2 && own == c) begin nst = 3; npres = 0; end
        else upd = 0;
      end
    endcase

    @(negedge clk);
    req_valid = 1; req_core = CW'(c); req_op = 2'(op); req_addr = AW'(a); busy = 1;
    @(posedge clk);
    snp_seen = 0; last_ack = -1; got = 0;
    for (int i = 0; i < NC; i++) ack_at[i] = -1;
    for (int cnt = 1; cnt <= 60 && got == 0; cnt++) begin
      @(negedge clk);
      if (cnt == 1) begin
        req_valid = 0;
        chk(req_ready == 0, "R11", "ready while busy", int'(req_ready), 0);
      end
      snp_ack = '0;
      for (int i = 0; i < NC; i++) if (ack_at[i] == cnt) snp_ack[i] = 1'b1;
      if (snp_valid) begin
        snp_seen++;
        chk(int'(snp_mask) == em, rq, "snoop mask", int'(snp_mask), em);
        chk(int'(snp_kind) == ek, rq, "snoop kind", int'(snp_kind), ek);
        chk(int'(snp_addr) == esa, rq, "snoop addr", int'(snp_addr), esa);
        for (int i = 0; i < NC; i++) if (snp_mask[i]) begin
          ack_at[i] = cnt + 1 + 2 * i;
          if (ack_at[i] > last_ack) last_ack = ack_at[i];
        end
      end
      if (rsp_valid) begin
        got = 1;
        chk(int'(rsp_hit) == hit, rq, "hit", int'(rsp_hit), hit);
        chk(int'(rsp_grant) == eg, rq, "grant", int'(rsp_grant), eg);
        chk(int'(rsp_core) == c, rq, "core", int'(rsp_core), c);
        chk(cnt == ((em != 0) ? last_ack + 2 : 3), rq, "latency", cnt,
            (em != 0) ? last_ack + 2 : 3);
      end
    end
    snp_ack = '0;
    chk(got == 1, rq, "response seen", got, 1);
    chk(snp_seen == ((em != 0) ? 1 : 0), rq, "snoop count", snp_seen, (em != 0) ? 1 : 0);
    @(negedge clk);
    busy = 0;
    if (!hit && op != 2 && vic >= 0) begin
      m_st.delete(vic); m_own.delete(vic); m_pres.delete(vic);
    end
    if (upd) begin m_st[a] = nst; m_own[a] = nown; m_pres[a] = npres; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && snp_valid == 0, "R1", "outputs in reset",
        {req_ready, rsp_valid, snp_valid}, 4);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && snp_valid == 0, "R1", "outputs after reset",
        {req_ready, rsp_valid, snp_valid}, 4);

    a = mk(1, 0);
    req(0, 0, a, -1, "R1");   // first access misses
    req(1, 0, a, -1, "R2");
    req(2, 1, a, -1, "R3");
    req(2, 0, a, -1, "R12");
    req(3, 0, a, -1, "R4");
    req(0, 1, a, -1, "R3");
    req(1, 1, a, -1, "R5");
    req(1, 1, a, -1, "R12");
    req(3, 2, a, -1, "R7");   // non-owner writeback ignored
    req(1, 2, a, -1, "R6");   // owner still core 1
    req(0, 0, a, -1, "R6");
    req(0, 2, mk(9, 5), -1, "R7");
    req(0, 0, mk(9, 5), -1, "R7");

    // set 1: clean-shared victim after in-order fill
    for (int t = 1; t <= 4; t++) req(0, 0, mk(t, 1), -1, "R8");
    req(1, 0, mk(5, 1), mk(1, 1), "R10");
    // set 2: a hit on way 0 bends the tree toward way 2
    req(3, 1, mk(1, 2), -1, "R8");
    for (int t = 2; t <= 4; t++) req(0, 0, mk(t, 2), -1, "R8");
    req(3, 0, mk(1, 2), -1, "R12");
    req(1, 0, mk(5, 2), mk(3, 2), "R10");
    // set 3: held victim recalled from its owner
    req(3, 1, mk(1, 3), -1, "R8");
    for (int t = 2; t <= 4; t++) req(0, 0, mk(t, 3), -1, "R8");
    req(1, 0, mk(5, 3), mk(1, 3), "R9");
    // set 4: outer-dirty victim needs no recall, then a shared one does
    req(1, 1, mk(1, 4), -1, "R8");
    req(1, 2, mk(1, 4), -1, "R6");
    for (int t = 2; t <= 4; t++) req(0, 0, mk(t, 4), -1, "R8");
    req(2, 1, mk(5, 4), mk(1, 4), "R9");
    req(2, 0, mk(1, 4), mk(3, 4), "R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule